// File: doc/BRIEF.md
# Serial Command Decoder for a Four-Channel Code Register Bank

This block sits between a 4-wire serial host link (active-low select, serial clock, data in, data out with a separate output enable) and four 8-bit channel code registers that feed downstream converters. The serial lines are oversampled by the system clock through synchronizer stages. Clock edges are found by comparing successive samples, so the whole block runs in one clock domain.

Each frame opens with a start bit of value 1. A 2-bit command and a 2-bit channel address follow. Depending on the command, the block then loads 8 data bits into a channel register, shifts a channel register out to the host, copies a channel's stored nonvolatile value (presented by an external store controller) into its register, or raises a one-cycle enable request toward that store controller. A mute input forces every channel code to zero while it is high.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: While select is low, zeros clocked in before the first 1 are ignored; the first 1 sampled on a rising serial clock edge is the start bit of a frame.
- R2: After the start bit, two command bits and then two address bits are taken MSB first. Command 00 is store enable, 01 is write, 10 is read and 11 is recall. Channel n is driven on `dac_code[8n+7:8n]`, and no other channel changes.
- R3: A write takes the next 8 bits MSB first into the addressed register. The channel code shows the new value once the eighth bit has been sampled.
- R4: After a write completes, further serial clocks in the same select period are ignored, including ones that look like a start bit, until select goes high.
- R5: A read drives the addressed register's 8 bits MSB first on `sdo`. Each bit changes after a falling serial edge, so the host samples D7 on the first rising edge after the address. The register and the channel code are left unchanged.
- R6: `sdo_oe` is low at all times other than the data phase of an accepted read, and it drops after select goes high.
- R7: A recall loads the addressed byte of `nv_word` into that channel register. Its data bits are optional, so select may rise right after the address.
- R8: A store enable command gives exactly one single-cycle pulse on `nv_en_req` and changes no register.
- R9: While `mute` is high, all channel codes read zero from the next clock on. When it is released, the register contents reappear, including any write that landed while muted.
- R10: Select going high aborts a partial frame; a write cut short before its eighth bit leaves the register unchanged.
- R11: A command whose header completes while `store_busy` is high is ignored: no register change, no pulse and no output enable.
- R12: After reset, all channel codes are zero and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | High while `sdo` should be driven onto the line |
| mute | input | 1 | Active-high mute, forces all codes to zero |
| store_busy | input | 1 | Store controller busy; commands are ignored while high |
| nv_word | input | 32 | Stored nonvolatile bytes, channel n at bits 8n+7:8n |
| nv_en_req | output | 1 | One-cycle store enable request |
| dac_code | output | 32 | Channel codes, channel n at bits 8n+7:8n |

## Verification
A write's eighth bit and a change of the mute input can reach the code register in the same system clock cycle. The bench raises mute on the same clock as the rising serial edge that carries the last data bit of a write. It expects every code to read zero while mute is held. After release it expects the freshly written byte, not the old value, and a following read must return that byte as well.

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl #(
  parameter int DW   = 8,
  parameter int AW   = 2,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_n,
  input  logic                 sclk,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdo_oe,
  input  logic                 mute,
  input  logic                 store_busy,
  input  logic [(DW<<AW)-1:0]  nv_word,
  output logic                 nv_en_req,
  output logic [(DW<<AW)-1:0]  dac_code
);
  localparam int NCH = 1 << AW;
  localparam int HW  = 2 + AW;
  localparam int CW  = $clog2(DW + HW);
  localparam logic [1:0] CMD_NVEN = 2'b00;
  localparam logic [1:0] CMD_WR   = 2'b01;
  localparam logic [1:0] CMD_RD   = 2'b10;

  typedef enum logic [1:0] {P_IDLE, P_HDR, P_DATA, P_DONE} phase_t;

  logic [SYNC-1:0] cs_sy, ck_sy, di_sy;
  logic            ck_d;
  logic            cs_hi, sck, bit_in, rise, fall;
  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [HW-1:0]   hdr;
  logic [HW-1:0]   hdr_full;
  logic [DW-1:0]   sh, out_sh;
  logic [AW-1:0]   cur_a;
  logic            is_rd, arm, rd_act;
  logic [DW-1:0]   regs [NCH];
  logic [(DW<<AW)-1:0] regs_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= '1;
      ck_sy <= '0;
      di_sy <= '0;
      ck_d  <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[SYNC-2:0], sel_n};
      ck_sy <= {ck_sy[SYNC-2:0], sclk};
      di_sy <= {di_sy[SYNC-2:0], sdi};
      ck_d  <= ck_sy[SYNC-1];
    end
  end

  assign cs_hi    = cs_sy[SYNC-1];
  assign sck      = ck_sy[SYNC-1];
  assign bit_in   = di_sy[SYNC-1];
  assign rise     = sck & ~ck_d;
  assign fall     = ~sck & ck_d;
  assign hdr_full = {hdr[HW-2:0], bit_in};
  assign sdo      = out_sh[DW-1];
  assign rd_act   = (phase == P_DATA) && is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= P_IDLE;
      cnt       <= '0;
      hdr       <= '0;
      sh        <= '0;
      out_sh    <= '0;
      cur_a     <= '0;
      is_rd     <= 1'b0;
      arm       <= 1'b0;
      sdo_oe    <= 1'b0;
      nv_en_req <= 1'b0;
      for (int i = 0; i < NCH; i++) regs[i] <= '0;
    end else begin
      nv_en_req <= 1'b0;
      if (cs_hi) begin
        phase  <= P_IDLE;
        cnt    <= '0;
        sdo_oe <= 1'b0;
        arm    <= 1'b0;
      end else begin
        if (rise) begin
          case (phase)
            P_IDLE: if (bit_in) begin
              phase <= P_HDR;
              cnt   <= '0;
            end
            P_HDR: begin
              hdr <= hdr_full;
              cnt <= cnt + 1'b1;
              if (cnt == CW'(HW-1)) begin
                cnt <= '0;
                if (store_busy) phase <= P_DONE;
                else begin
                  case (hdr_full[HW-1 -: 2])
                    CMD_NVEN: begin
                      nv_en_req <= 1'b1;
                      phase     <= P_DONE;
                    end
                    CMD_WR: begin
                      phase <= P_DATA;
                      is_rd <= 1'b0;
                      cur_a <= hdr_full[AW-1:0];
                    end
                    CMD_RD: begin
                      phase  <= P_DATA;
                      is_rd  <= 1'b1;
                      out_sh <= regs[hdr_full[AW-1:0]];
                      arm    <= 1'b1;
                    end
                    default: begin
                      regs[hdr_full[AW-1:0]] <= nv_word[hdr_full[AW-1:0]*DW +: DW];
                      phase <= P_DONE;
                    end
                  endcase
                end
              end
            end
            P_DATA: begin
              sh  <= {sh[DW-2:0], bit_in};
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DW-1)) begin
                phase <= P_DONE;
                if (is_rd) sdo_oe <= 1'b0;
                else regs[cur_a] <= {sh[DW-2:0], bit_in};
              end
            end
            default: ;
          endcase
        end
        if (fall) begin
          if (arm) begin
            sdo_oe <= 1'b1;
            arm    <= 1'b0;
          end else if (sdo_oe) begin
            out_sh <= out_sh << 1;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign regs_flat[c*DW +: DW] = regs[c];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_code[c*DW +: DW] <= '0;
      else        dac_code[c*DW +: DW] <= mute ? '0 : regs[c];
    end
  end
endmodule

module qdac_serial_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mute,
  input logic         store_busy,
  input logic         sdo_oe,
  input logic         nv_en_req,
  input logic         cs_hi,
  input logic         rd_act,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] regs_flat
);
  // R9
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute |=> (dac_code == '0));
  // R9
  unmute_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |=> (dac_code == $past(regs_flat)));
  // R6
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !sdo_oe);
  // R8
  nv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_en_req |=> !nv_en_req);
  // R11
  busy_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_en_req |-> !$past(store_busy));
  // R5
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> $stable(regs_flat));
endmodule

bind qdac_serial_ctrl qdac_serial_ctrl_chk #(.W(DW<<AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .mute(mute), .store_busy(store_busy),
  .sdo_oe(sdo_oe), .nv_en_req(nv_en_req), .cs_hi(cs_hi), .rd_act(rd_act),
  .dac_code(dac_code), .regs_flat(regs_flat)
);

// File: tb/test_qdac_serial_ctrl.sv
`timescale 1ns/1ps
module test_qdac_serial_ctrl;
  localparam int H = 6;

  logic clk = 0, rst_n = 0, sel_n = 1, sclk = 0, sdi = 0, mute = 0, store_busy = 0;
  logic [31:0] nv_word = 32'h43_77_21_10;
  logic sdo, sdo_oe, nv_en_req;
  logic [31:0] dac_code;

  int checks = 0, failures = 0, nv_pulses = 0;
  logic [7:0] expq[$];
  logic [7:0] acc = 0;
  int nbits = 0;

  always #2.5 clk = ~clk;

  qdac_serial_ctrl i_qdac_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .mute(mute), .store_busy(store_busy),
    .nv_word(nv_word), .nv_en_req(nv_en_req), .dac_code(dac_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) if (rst_n && nv_en_req) nv_pulses++;

  // monitor: collect read bits at host sampling edges and compare with queue
  always @(posedge sclk) begin
    if (sdo_oe) begin
      acc = {acc[6:0], sdo};
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        if (expq.size() == 0) check(0, "R6 unexpected read data", acc, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(acc == e, "R5 read data", acc, e);
        end
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdi = b;
    wt(H);
    sclk = 1;
    wt(H);
    sclk = 0;
  endtask

  task automatic frame(input logic [1:0] cmd, input logic [1:0] a, input logic [7:0] d,
                       input int lead, input int ndata, input int extra);
    sel_n = 0;
    wt(H);
    for (int i = 0; i < lead; i++) sbit(1'b0);
    sbit(1'b1);
    sbit(cmd[1]); sbit(cmd[0]);
    sbit(a[1]);   sbit(a[0]);
    for (int i = 0; i < ndata; i++) sbit(d[7-i]);
    for (int i = 0; i < extra; i++) sbit(i % 3 != 1);
    wt(H);
    sel_n = 1;
    wt(3*H);
  endtask

  task automatic chk_code(input int ch, input logic [7:0] exp, input string tag);
    check(dac_code[ch*8 +: 8] == exp, tag, dac_code[ch*8 +: 8], exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    wt(4);
    rst_n = 1;
    wt(4);
    // R12
    check(dac_code == 0, "R12 reset codes", dac_code, 0);
    check(sdo_oe == 0, "R12 reset oe", sdo_oe, 0);

    // R1 leading zeros, R3 write, R2 other channels untouched
    frame(2'b01, 2'd1, 8'hA5, 3, 8, 0);
    chk_code(1, 8'hA5, "R1 R3 write ch1 after leading zeros");
    check(dac_code == 32'h0000_A500, "R2 only ch1 changed", dac_code, 32'h0000_A500);
    frame(2'b01, 2'd3, 8'h3C, 0, 8, 0);
    chk_code(3, 8'h3C, "R3 write ch3");

    // R5 reads
    expq.push_back(8'hA5);
    frame(2'b10, 2'd1, 8'h00, 0, 8, 0);
    chk_code(1, 8'hA5, "R5 read leaves ch1");
    expq.push_back(8'h3C);
    frame(2'b10, 2'd3, 8'h00, 0, 8, 0);
    check(sdo_oe == 0, "R6 oe low after read", sdo_oe, 0);

    // R4 write consumes frame, trailing clocks ignored
    frame(2'b01, 2'd2, 8'h81, 0, 8, 12);
    chk_code(2, 8'h81, "R4 ch2 keeps first byte");
    check(dac_code == 32'h3C81_A500, "R4 trailing clocks ignored", dac_code, 32'h3C81_A500);

    // R10 abort of partial write
    frame(2'b01, 2'd1, 8'h0F, 0, 4, 0);
    chk_code(1, 8'hA5, "R10 partial write aborted");

    // R7 recall, select raised right after address
    frame(2'b11, 2'd2, 8'h00, 0, 0, 0);
    chk_code(2, 8'h77, "R7 recall ch2");

    // R8 store enable
    frame(2'b00, 2'd0, 8'hFF, 0, 8, 0);
    check(nv_pulses == 1, "R8 one enable pulse", nv_pulses, 1);
    check(dac_code == 32'h3C77_A500, "R8 codes unchanged", dac_code, 32'h3C77_A500);

    // R11 busy: write, enable and read are all ignored
    store_busy = 1;
    frame(2'b01, 2'd0, 8'h11, 0, 8, 0);
    frame(2'b00, 2'd0, 8'h00, 0, 8, 0);
    frame(2'b10, 2'd1, 8'h00, 0, 8, 0);
    store_busy = 0;
    chk_code(0, 8'h00, "R11 busy write ignored");
    check(nv_pulses == 1, "R11 busy enable ignored", nv_pulses, 1);

    // R9 mute raised together with the last write bit
    sel_n = 0;
    wt(H);
    sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b0);
    for (int i = 0; i < 7; i++) sbit(8'h5A >> (7 - i));
    sdi = 1'b0;
    wt(H);
    sclk = 1;
    mute = 1;
    wt(H);
    sclk = 0;
    wt(H);
    sel_n = 1;
    wt(3*H);
    check(dac_code == 0, "R9 all codes zero while muted", dac_code, 0);
    mute = 0;
    wt(3);
    check(dac_code == 32'h3C77_A55A, "R9 restore with coincident write", dac_code, 32'h3C77_A55A);
    expq.push_back(8'h5A);
    frame(2'b10, 2'd0, 8'h00, 0, 8, 0);
    check(expq.size() == 0, "R5 all reads returned", expq.size(), 0);
    report();
  end
endmodule